// File: doc/BRIEF.md
# Pseudo-DMA Byte Port

This block is the host-facing data window of a disk-bus controller. The host does not get a bus-mastering engine. It moves the bytes of a transfer itself, through a narrow access port. The controller arms the window with a starting buffer index and a byte length. The block then asserts a data-request line. Each host access moves one or two bytes between the port and an internal byte buffer at a running index. Each access also lowers the remaining length and a separately loaded transfer counter. When the last byte has moved, the request line drops and a one-cycle done pulse reports how many bytes went through.

A second, plain byte port gives the owner of the buffer direct access to it. The owner uses it to fill the buffer before a host read and to inspect it after a host write. The contents of the buffer have no meaning to this block.

Top module: `pdma_port`

## Requirements
- R1: After reset, drq_o, done_o, acc_rdata_o, tc_o and done_count_o are all zero, and every buffer byte reads zero.
- R2: An arm with a nonzero length raises drq_o on the next cycle. An arm with length zero leaves drq_o low. An arm in the same cycle as a host access wins, and that access is dropped.
- R3: A taken 1-byte write (acc_wide_i=0) stores acc_wdata_i[7:0] at the current index. It then advances the index by 1 and lowers the remaining length and tc_o by 1.
- R4: A taken 2-byte write (acc_wide_i=1) stores acc_wdata_i[15:8] at the current index and acc_wdata_i[7:0] at the index after it. It lowers the length and tc_o by 2.
- R5: A host write has no effect when tc_o is zero or the remaining length is zero. The buffer, tc_o and drq_o stay as they were, and no done pulse follows.
- R6: A taken read updates acc_rdata_o on the following cycle. A 1-byte read returns {8'h00, byte at index}. A 2-byte read returns {byte at index, byte at index+1}. Reads lower the length and tc_o like writes.
- R7: A read with remaining length zero sets acc_rdata_o to 0 and leaves tc_o and the buffer unchanged.
- R8: The access that brings the remaining length to zero clears drq_o and raises done_o for exactly one cycle, both visible after that access's clock edge. done_count_o then holds the number of bytes moved since the arm.
- R9: A 2-byte access with one byte left moves only the upper byte. A write stores acc_wdata_i[15:8]; a read returns {byte, 8'h00}. That access ends the transfer. tc_o saturates at zero and never wraps.
- R10: tc_load_i sets tc_o to tc_val_i on the next cycle. It takes precedence over the decrement of an access in the same cycle.
- R11: The running buffer index wraps modulo DEPTH (32 by default), so a 2-byte access at index 31 uses bytes 31 and 0.
- R12: buf_we_i writes buf_wdata_i at buf_addr_i. buf_rdata_o shows the byte at buf_addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm a new transfer |
| arm_start_i | input | IDX_W (5) | First buffer index of the transfer |
| arm_len_i | input | LEN_W (6) | Byte length of the transfer |
| tc_load_i | input | 1 | Load the transfer counter |
| tc_val_i | input | TC_W (16) | Value to load into the transfer counter |
| acc_i | input | 1 | Host access strobe |
| acc_we_i | input | 1 | 1 = host write, 0 = host read |
| acc_wide_i | input | 1 | 1 = 2-byte access, 0 = 1-byte access |
| acc_wdata_i | input | 16 | Host write data |
| acc_rdata_o | output | 16 | Host read data, registered |
| buf_we_i | input | 1 | Side-port byte write |
| buf_addr_i | input | IDX_W (5) | Side-port byte address |
| buf_wdata_i | input | 8 | Side-port write byte |
| buf_rdata_o | output | 8 | Side-port read byte |
| drq_o | output | 1 | Data request, high while a transfer has bytes left |
| done_o | output | 1 | One-cycle completion pulse |
| done_count_o | output | LEN_W (6) | Bytes moved by the last completed transfer |
| tc_o | output | TC_W (16) | Transfer counter |

## Verification
A wrong running index appears on the side port as a byte stored one place off, or as swapped halves of a 2-byte word. It also appears in the next host read. Either shows up within a cycle of the faulty access. A wrong remaining length shows first as done_o firing one access early or late, or never. drq_o and done_count_o then disagree with the byte count the bench armed. A counter that misses its zero gate lets a write land in the buffer, and that is visible at once on buf_rdata_o.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  // Bytes an access moves: two only for a wide access with at least two left.
  function automatic logic [1:0] xfer_step(input logic wide, input logic one_left);
    return (wide && !one_left) ? 2'd2 : 2'd1;
  endfunction

  // Subtraction that stops at zero.
  function automatic int unsigned floor_sub(input int unsigned a, input int unsigned b);
    return (a > b) ? a - b : 0;
  endfunction

  // Host read word from the bytes at the index and the one after it.
  function automatic logic [15:0] pack_read(input logic wide, input logic two,
                                            input logic [7:0] hi, input logic [7:0] lo);
    if (!wide) return {8'h00, hi};
    return two ? {hi, lo} : {hi, 8'h00};
  endfunction

endpackage

// File: rtl/pdma_buf.sv
module pdma_buf #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en0_i,
  input  logic [IDX_W-1:0] idx0_i,
  input  logic [7:0]       d0_i,
  input  logic             en1_i,
  input  logic [IDX_W-1:0] idx1_i,
  input  logic [7:0]       d1_i,
  input  logic             side_we_i,
  input  logic [IDX_W-1:0] side_addr_i,
  input  logic [7:0]       side_d_i,
  output logic [7:0]       q0_o,
  output logic [7:0]       q1_o,
  output logic [7:0]       side_q_o
);

  logic [7:0] mem [DEPTH];

  // One byte cell per entry; host lanes win over the side port.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= 8'h00;
      else if (en0_i && idx0_i == IDX_W'(g))
        mem[g] <= d0_i;
      else if (en1_i && idx1_i == IDX_W'(g))
        mem[g] <= d1_i;
      else if (side_we_i && side_addr_i == IDX_W'(g))
        mem[g] <= side_d_i;
    end
  end

  assign q0_o     = mem[idx0_i];
  assign q1_o     = mem[idx1_i];
  assign side_q_o = mem[side_addr_i];

endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl #(
  parameter int DEPTH = 32,
  parameter int TC_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [IDX_W-1:0] arm_start_i,
  input  logic [LEN_W-1:0] arm_len_i,
  input  logic             tc_load_i,
  input  logic [TC_W-1:0]  tc_val_i,
  input  logic             acc_i,
  input  logic             acc_we_i,
  input  logic             acc_wide_i,
  input  logic [15:0]      acc_wdata_i,
  input  logic [7:0]       byte0_i,
  input  logic [7:0]       byte1_i,
  output logic [IDX_W-1:0] idx0_o,
  output logic [IDX_W-1:0] idx1_o,
  output logic             wr0_o,
  output logic             wr1_o,
  output logic [7:0]       wd0_o,
  output logic [7:0]       wd1_o,
  output logic [15:0]      rdata_o,
  output logic             drq_o,
  output logic             done_o,
  output logic [LEN_W-1:0] done_count_o,
  output logic [TC_W-1:0]  tc_o,
  output logic             ev_take_o,
  output logic             ev_last_o
);

  logic [IDX_W-1:0] start_q, cur_q;
  logic [LEN_W-1:0] len_q, moved_q, len_next;
  logic [TC_W-1:0]  tc_q;
  logic             drq_q, done_q;
  logic [LEN_W-1:0] cnt_q;
  logic [15:0]      rdata_q;
  logic [1:0]       step;
  logic             take_wr, take_rd, take, last;

  // Event decode: an arm in the same cycle blocks any access.
  assign step     = pdma_pkg::xfer_step(acc_wide_i, len_q == LEN_W'(1));
  assign take_wr  = acc_i && acc_we_i && !arm_i && (len_q != '0) && (tc_q != '0);
  assign take_rd  = acc_i && !acc_we_i && !arm_i && (len_q != '0);
  assign take     = take_wr || take_rd;
  assign len_next = len_q - LEN_W'(step);
  assign last     = take && (len_next == '0);

  // Buffer lane drive.
  assign idx0_o = cur_q;
  assign idx1_o = cur_q + IDX_W'(1);
  assign wr0_o  = take_wr;
  assign wr1_o  = take_wr && (step == 2'd2);
  assign wd0_o  = acc_wide_i ? acc_wdata_i[15:8] : acc_wdata_i[7:0];
  assign wd1_o  = acc_wdata_i[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cur_q   <= '0;
      len_q   <= '0;
      moved_q <= '0;
      drq_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (arm_i) begin
        start_q <= arm_start_i;
        cur_q   <= arm_start_i;
        len_q   <= arm_len_i;
        moved_q <= '0;
        drq_q   <= (arm_len_i != '0);
      end else if (take) begin
        cur_q   <= cur_q + IDX_W'(step);
        len_q   <= len_next;
        moved_q <= moved_q + LEN_W'(step);
        if (last) begin
          drq_q  <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= moved_q + LEN_W'(step);
        end
      end
      if (acc_i && !acc_we_i && !arm_i)
        rdata_q <= take_rd ? pdma_pkg::pack_read(acc_wide_i, step == 2'd2, byte0_i, byte1_i)
                           : 16'h0000;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      tc_q <= '0;
    else if (tc_load_i)
      tc_q <= tc_val_i;
    else if (take)
      tc_q <= TC_W'(pdma_pkg::floor_sub(32'(tc_q), 32'(step)));
  end

  assign rdata_o      = rdata_q;
  assign drq_o        = drq_q;
  assign done_o       = done_q;
  assign done_count_o = cnt_q;
  assign tc_o         = tc_q;
  assign ev_take_o    = take;
  assign ev_last_o    = last;

endmodule

// File: rtl/pdma_port.sv
module pdma_port #(
  parameter int DEPTH = 32,
  parameter int TC_W  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [IDX_W-1:0] arm_start_i,
  input  logic [LEN_W-1:0] arm_len_i,
  input  logic             tc_load_i,
  input  logic [TC_W-1:0]  tc_val_i,
  input  logic             acc_i,
  input  logic             acc_we_i,
  input  logic             acc_wide_i,
  input  logic [15:0]      acc_wdata_i,
  output logic [15:0]      acc_rdata_o,
  input  logic             buf_we_i,
  input  logic [IDX_W-1:0] buf_addr_i,
  input  logic [7:0]       buf_wdata_i,
  output logic [7:0]       buf_rdata_o,
  output logic             drq_o,
  output logic             done_o,
  output logic [LEN_W-1:0] done_count_o,
  output logic [TC_W-1:0]  tc_o
);

  logic [IDX_W-1:0] idx0, idx1;
  logic             wr0, wr1;
  logic [7:0]       wd0, wd1, q0, q1;
  logic             ev_take, ev_last;

  pdma_ctrl #(.DEPTH(DEPTH), .TC_W(TC_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .arm_i        (arm_i),
    .arm_start_i  (arm_start_i),
    .arm_len_i    (arm_len_i),
    .tc_load_i    (tc_load_i),
    .tc_val_i     (tc_val_i),
    .acc_i        (acc_i),
    .acc_we_i     (acc_we_i),
    .acc_wide_i   (acc_wide_i),
    .acc_wdata_i  (acc_wdata_i),
    .byte0_i      (q0),
    .byte1_i      (q1),
    .idx0_o       (idx0),
    .idx1_o       (idx1),
    .wr0_o        (wr0),
    .wr1_o        (wr1),
    .wd0_o        (wd0),
    .wd1_o        (wd1),
    .rdata_o      (acc_rdata_o),
    .drq_o        (drq_o),
    .done_o       (done_o),
    .done_count_o (done_count_o),
    .tc_o         (tc_o),
    .ev_take_o    (ev_take),
    .ev_last_o    (ev_last)
  );

  pdma_buf #(.DEPTH(DEPTH)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .en0_i       (wr0),
    .idx0_i      (idx0),
    .d0_i        (wd0),
    .en1_i       (wr1),
    .idx1_i      (idx1),
    .d1_i        (wd1),
    .side_we_i   (buf_we_i),
    .side_addr_i (buf_addr_i),
    .side_d_i    (buf_wdata_i),
    .q0_o        (q0),
    .q1_o        (q1),
    .side_q_o    (buf_rdata_o)
  );

endmodule

// File: rtl/pdma_port_chk.sv
module pdma_port_chk #(
  parameter int TC_W  = 16,
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_i,
  input logic [LEN_W-1:0] arm_len_i,
  input logic             acc_i,
  input logic             acc_we_i,
  input logic             tc_load_i,
  input logic [TC_W-1:0]  tc_o,
  input logic             drq_o,
  input logic             done_o,
  input logic             ev_take,
  input logic             ev_last
);

  p_arm_raises_drq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i && arm_len_i != '0 |=> drq_o);

  p_arm_blocks_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |-> !ev_take);

  p_tc_zero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i && acc_we_i && tc_o == '0 && !tc_load_i |=> tc_o == '0);

  p_last_gives_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> done_o && !drq_o);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_no_drq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !drq_o);

  p_tc_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_load_i |=> tc_o <= $past(tc_o));

endmodule

bind pdma_port pdma_port_chk #(.TC_W(TC_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm_i     (arm_i),
  .arm_len_i (arm_len_i),
  .acc_i     (acc_i),
  .acc_we_i  (acc_we_i),
  .tc_load_i (tc_load_i),
  .tc_o      (tc_o),
  .drq_o     (drq_o),
  .done_o    (done_o),
  .ev_take   (ev_take),
  .ev_last   (ev_last)
);

// File: tb/sim_pdma_port.sv
`timescale 1ns/1ps
module sim_pdma_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_i = 1'b0;
  logic [4:0]  arm_start_i = '0;
  logic [5:0]  arm_len_i = '0;
  logic        tc_load_i = 1'b0;
  logic [15:0] tc_val_i = '0;
  logic        acc_i = 1'b0, acc_we_i = 1'b0, acc_wide_i = 1'b0;
  logic [15:0] acc_wdata_i = '0;
  logic [15:0] acc_rdata_o;
  logic        buf_we_i = 1'b0;
  logic [4:0]  buf_addr_i = '0;
  logic [7:0]  buf_wdata_i = '0;
  logic [7:0]  buf_rdata_o;
  logic        drq_o, done_o;
  logic [5:0]  done_count_o;
  logic [15:0] tc_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pdma_port u0 (.*);

  // Write table: [17] wide, [16:1] data, [0] expected done after the access.
  localparam logic [17:0] WR_VEC [4] = '{
    {1'b0, 16'h00AB, 1'b0},
    {1'b1, 16'h1234, 1'b0},
    {1'b1, 16'h5678, 1'b0},
    {1'b0, 16'h009C, 1'b1}
  };
  localparam logic [7:0] WR_BYTES [6] = '{8'hAB, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9C};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic arm(input logic [4:0] s, input logic [5:0] n);
    @(negedge clk);
    arm_i = 1'b1; arm_start_i = s; arm_len_i = n;
    @(negedge clk);
    arm_i = 1'b0;
  endtask

  task automatic load_tc(input logic [15:0] v);
    @(negedge clk);
    tc_load_i = 1'b1; tc_val_i = v;
    @(negedge clk);
    tc_load_i = 1'b0;
  endtask

  // Drives one access for one clock; returns at the next falling edge.
  task automatic acc(input logic we, input logic wide, input logic [15:0] wd);
    @(negedge clk);
    acc_i = 1'b1; acc_we_i = we; acc_wide_i = wide; acc_wdata_i = wd;
    @(negedge clk);
    acc_i = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [7:0] v);
    buf_addr_i = a;
    #1 v = buf_rdata_o;
  endtask

  task automatic poke(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk);
    buf_we_i = 1'b1; buf_addr_i = a; buf_wdata_i = v;
    @(negedge clk);
    buf_we_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 drq", drq_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 rdata", acc_rdata_o, 0);
    chk("R1 tc", tc_o, 0);
    peek(5'd7, b); chk("R1 buf", b, 0);

    // R2, R3, R4, R8: table of writes, 6 bytes from index 4
    load_tc(16'd100);
    chk("R10 tc load", tc_o, 100);
    arm(5'd4, 6'd6);
    chk("R2 drq after arm", drq_o, 1);
    for (int i = 0; i < 4; i++) begin
      acc(1'b1, WR_VEC[i][17], WR_VEC[i][16:1]);
      chk("R8 done per step", done_o, WR_VEC[i][0]);
      chk("R8 drq per step", drq_o, !WR_VEC[i][0]);
    end
    chk("R8 done count", done_count_o, 6);
    chk("R3 R4 tc after writes", tc_o, 94);
    @(negedge clk);
    chk("R8 done one cycle", done_o, 0);
    for (int i = 0; i < 6; i++) begin
      peek(5'(4 + i), b);
      chk("R3 R4 stored byte", b, WR_BYTES[i]);
    end

    // R6: reads of 3 bytes from index 4
    arm(5'd4, 6'd3);
    acc(1'b0, 1'b1, 16'h0);
    chk("R6 wide read", acc_rdata_o, 16'hAB12);
    acc(1'b0, 1'b0, 16'h0);
    chk("R6 narrow read", acc_rdata_o, 16'h0034);
    chk("R8 done after read", done_o, 1);
    chk("R6 tc after reads", tc_o, 91);

    // R7: read with nothing left
    acc(1'b0, 1'b1, 16'h0);
    chk("R7 read zero", acc_rdata_o, 0);
    chk("R7 tc kept", tc_o, 91);

    // R5: write with counter zero
    load_tc(16'd0);
    arm(5'd0, 6'd2);
    acc(1'b1, 1'b0, 16'h00EE);
    peek(5'd0, b); chk("R5 tc zero no store", b, 0);
    chk("R5 drq kept", drq_o, 1);
    chk("R5 no done", done_o, 0);
    chk("R5 tc stays", tc_o, 0);

    // R2, R5: zero-length arm, write ignored
    load_tc(16'd9);
    arm(5'd1, 6'd0);
    chk("R2 zero length drq", drq_o, 0);
    acc(1'b1, 1'b0, 16'h00DD);
    peek(5'd1, b); chk("R5 len zero no store", b, 0);
    chk("R5 len zero tc", tc_o, 9);

    // R9: wide access with one byte left, counter saturates
    load_tc(16'd1);
    arm(5'd10, 6'd1);
    acc(1'b1, 1'b1, 16'hC3D4);
    peek(5'd10, b); chk("R9 upper byte stored", b, 8'hC3);
    peek(5'd11, b); chk("R9 next untouched", b, 0);
    chk("R9 done", done_o, 1);
    chk("R9 count", done_count_o, 1);
    chk("R9 tc floor", tc_o, 0);
    poke(5'd12, 8'h5E);
    load_tc(16'd4);
    arm(5'd12, 6'd1);
    acc(1'b0, 1'b1, 16'h0);
    chk("R9 wide read tail", acc_rdata_o, 16'h5E00);
    chk("R12 side write seen", acc_rdata_o[15:8], 8'h5E);

    // R11: wrap at the top of the buffer
    load_tc(16'd10);
    arm(5'd31, 6'd2);
    acc(1'b1, 1'b1, 16'h7788);
    peek(5'd31, b); chk("R11 byte at 31", b, 8'h77);
    peek(5'd0, b); chk("R11 byte at 0", b, 8'h88);

    // R2: arm wins over a same-cycle access
    load_tc(16'd50);
    @(negedge clk);
    arm_i = 1'b1; arm_start_i = 5'd20; arm_len_i = 6'd2;
    acc_i = 1'b1; acc_we_i = 1'b1; acc_wide_i = 1'b0; acc_wdata_i = 16'h005A;
    @(negedge clk);
    arm_i = 1'b0; acc_i = 1'b0;
    peek(5'd20, b); chk("R2 access dropped", b, 0);
    chk("R2 tc unchanged", tc_o, 50);
    chk("R2 drq armed", drq_o, 1);

    // R10: load beats the decrement of a same-cycle access
    @(negedge clk);
    tc_load_i = 1'b1; tc_val_i = 16'd7;
    acc_i = 1'b1; acc_we_i = 1'b1; acc_wide_i = 1'b0; acc_wdata_i = 16'h0066;
    @(negedge clk);
    tc_load_i = 1'b0; acc_i = 1'b0;
    chk("R10 load wins", tc_o, 7);
    peek(5'd20, b); chk("R10 write taken", b, 8'h66);

    summary();
  end

endmodule